// File: doc/BRIEF.md
# Reset Cause Status Register

This block is an 8-bit control and status register. It records why the device last came out of reset, and it tracks sleep and watchdog activity. Hardware sources drive one-cycle event pulses into it: a power-on reset, a brown-out reset, a watchdog expiry, a watchdog-clear instruction, a sleep instruction and a software reset instruction. The processor reads the register combinationally and writes it through a simple strobe-and-data bus. The register also holds the enable bit for interrupt priority levels.

Each flag has its own rules for setting and clearing. Several flags are cleared by the event they report. Software must then write them back to 1, so that the next occurrence of that event can be seen.

When a hardware event and a software write hit the same flag in one cycle, the hardware event wins. The other flags written in that cycle still take the written value.

Top module: `rst_cause_reg`

## Requirements
- R1: Bit positions in `rd_data` are fixed: bit 7 = priority enable, bits 6:5 = unused, bit 4 = reset-instruction flag, bit 3 = watchdog time-out flag, bit 2 = power-down flag, bit 1 = power-on flag, bit 0 = brown-out flag. `prio_en` always equals bit 7.
- R2: Bits 6:5 always read 0, and writes to them have no effect.
- R3: Both the asynchronous reset and an `ev_por` pulse load the value 0x1C: priority enable 0, reset-instruction 1, time-out 1, power-down 1, power-on 0, brown-out 0.
- R4: `ev_wdt_to` clears the time-out flag. `ev_wdt_clr` or `ev_sleep` sets it. If an expiry arrives in the same cycle as a clear or a sleep, the expiry wins.
- R5: `ev_wdt_clr` sets the power-down flag and `ev_sleep` clears it. If both arrive in one cycle, the sleep wins.
- R6: Only `ev_por` clears the power-on flag. `ev_bor` leaves it unchanged.
- R7: The brown-out flag is cleared by `ev_bor` and by `ev_por`.
- R8: `ev_sw_rst` clears the reset-instruction flag.
- R9: On a clock edge where `wr_en` is 1 and no event is pulsed, bits 7 and 4:0 take the value of `wr_data`.
- R10: When a write and a hardware event hit the same flag in one cycle, the event's value is stored. The other flags take the written data.
- R11: With no event and no write, the register holds its value. `rd_data` shows the stored value with no added cycle of delay.
- R12: The priority enable bit changes only by a software write or by `ev_por`, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| ev_por | input | 1 | Power-on reset event pulse |
| ev_bor | input | 1 | Brown-out reset event pulse |
| ev_wdt_to | input | 1 | Watchdog expiry pulse |
| ev_wdt_clr | input | 1 | Watchdog-clear instruction pulse |
| ev_sleep | input | 1 | Sleep instruction pulse |
| ev_sw_rst | input | 1 | Software reset instruction pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| prio_en | output | 1 | Interrupt priority levels enabled |

## Verification
The assertions assume that every event input is a synchronous level, sampled only at rising clock edges, and that inputs are never unknown after reset. Several properties are also guarded by the absence of a power-on event, because that event overrides every other rule. The bench drives all inputs half a cycle away from the active edge. It holds each event for exactly one cycle and returns every input to 0 between scenarios, so each check sees only the stimulus it intends.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int REG_W = 8;

  // Bit positions (behavioural: the priority logic and readers decode them)
  localparam int B_IPEN = 7;
  localparam int B_RI   = 4;
  localparam int B_TO   = 3;
  localparam int B_PD   = 2;
  localparam int B_POR  = 1;
  localparam int B_BOR  = 0;

  localparam logic [REG_W-1:0] IMPL_MASK  = 8'h9F;
  localparam logic [REG_W-1:0] PWR_ON_VAL = 8'h1C;

  // Next state of one flag: hardware clear beats hardware set beats write.
  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic hw_clr, input logic we,
                                     input logic wd);
    logic nxt;
    if (hw_clr)      nxt = 1'b0;
    else if (hw_set) nxt = 1'b1;
    else if (we)     nxt = wd;
    else             nxt = cur;
    return nxt;
  endfunction
endpackage

// File: rtl/rcause_evt_decode.sv
module rcause_evt_decode
  import rcause_pkg::*;
(
  input  logic             ev_por,
  input  logic             ev_bor,
  input  logic             ev_wdt_to,
  input  logic             ev_wdt_clr,
  input  logic             ev_sleep,
  input  logic             ev_sw_rst,
  output logic [REG_W-1:0] set_v,
  output logic [REG_W-1:0] clr_v
);
  // Named per-flag events, kept visible for checking
  logic to_expire, to_rearm, pd_wake, pd_down, ri_hit, bor_hit;

  assign to_expire = ev_wdt_to & ~ev_por;
  assign to_rearm  = (ev_wdt_clr | ev_sleep) & ~ev_wdt_to;
  assign pd_down   = ev_sleep & ~ev_por;
  assign pd_wake   = ev_wdt_clr & ~ev_sleep;
  assign ri_hit    = ev_sw_rst & ~ev_por;
  assign bor_hit   = ev_bor | ev_por;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    // power-on loads the full power-up image
    for (int i = 0; i < REG_W; i++) begin
      if (IMPL_MASK[i]) begin
        set_v[i] = ev_por &  PWR_ON_VAL[i];
        clr_v[i] = ev_por & ~PWR_ON_VAL[i];
      end
    end
    clr_v[B_TO]  = to_expire;
    set_v[B_TO]  = ev_por | to_rearm;
    clr_v[B_PD]  = pd_down;
    set_v[B_PD]  = ev_por | pd_wake;
    clr_v[B_RI]  = ri_hit;
    clr_v[B_BOR] = bor_hit;
  end
endmodule

// File: rtl/rcause_flag_cell.sv
module rcause_flag_cell
  import rcause_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic we,
  input  logic wd,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= flag_next(q, hw_set, hw_clr, we, wd);
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcause_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_por,
  input  logic             ev_bor,
  input  logic             ev_wdt_to,
  input  logic             ev_wdt_clr,
  input  logic             ev_sleep,
  input  logic             ev_sw_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             prio_en
);
  logic [REG_W-1:0] set_v, clr_v, q;

  rcause_evt_decode u_dec (
    .ev_por(ev_por), .ev_bor(ev_bor), .ev_wdt_to(ev_wdt_to),
    .ev_wdt_clr(ev_wdt_clr), .ev_sleep(ev_sleep), .ev_sw_rst(ev_sw_rst),
    .set_v(set_v), .clr_v(clr_v)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      rcause_flag_cell #(.RST_VAL(PWR_ON_VAL[i])) u_cell (
        .clk(clk), .rst_n(rst_n), .hw_set(set_v[i]), .hw_clr(clr_v[i]),
        .we(wr_en), .wd(wr_data[i]), .q(q[i])
      );
    end else begin : g_void
      // no storage: reads as zero whatever is written or decoded
      assign q[i] = 1'b0 & (wr_data[i] | set_v[i] | clr_v[i]);
    end
  end

  assign rd_data = q;
  assign prio_en = q[B_IPEN];
endmodule

// File: rtl/rcause_chk.sv
module rcause_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_por,
  input logic       ev_bor,
  input logic       ev_wdt_to,
  input logic       ev_wdt_clr,
  input logic       ev_sleep,
  input logic       ev_sw_rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       prio_en
);
  logic any_ev;
  assign any_ev = ev_por | ev_bor | ev_wdt_to | ev_wdt_clr | ev_sleep | ev_sw_rst;

  assert_prio_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prio_en == rd_data[7]);
  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:5] == 2'b00);
  assert_por_image_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_por |=> rd_data == 8'h1C);
  assert_to_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt_to && !ev_por) |=> !rd_data[3]);
  assert_pd_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sleep && !ev_por) |=> !rd_data[2]);
  assert_por_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bor && !ev_por && !wr_en) |=> $stable(rd_data[1]));
  assert_bor_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bor || ev_por) |=> !rd_data[0]);
  assert_ri_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sw_rst && !ev_por) |=> !rd_data[4]);
  assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_ev) |=> rd_data == ($past(wr_data) & 8'h9F));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !any_ev) |=> $stable(rd_data));
endmodule

bind rst_cause_reg rcause_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor),
  .ev_wdt_to(ev_wdt_to), .ev_wdt_clr(ev_wdt_clr), .ev_sleep(ev_sleep),
  .ev_sw_rst(ev_sw_rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .prio_en(prio_en)
);

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_por = 0, ev_bor = 0, ev_wdt_to = 0, ev_wdt_clr = 0, ev_sleep = 0, ev_sw_rst = 0;
  logic wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic prio_en;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg u_dut (
    .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor),
    .ev_wdt_to(ev_wdt_to), .ev_wdt_clr(ev_wdt_clr), .ev_sleep(ev_sleep),
    .ev_sw_rst(ev_sw_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .prio_en(prio_en)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // apply inputs at negedge, let one edge pass, sample at next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    {ev_por, ev_bor, ev_wdt_to, ev_wdt_clr, ev_sleep, ev_sw_rst, wr_en} = '0;
    wr_data = '0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; step();
  endtask

  task automatic t_reset();
    check("R3 reset value", rd_data, 8'h1C);
    check("R1 prio_en after reset", {7'd0, prio_en}, 8'h00);
  endtask

  task automatic t_write();
    wr(8'hFF);
    check("R2/R9 write all ones", rd_data, 8'h9F);
    check("R12 prio_en set", {7'd0, prio_en}, 8'h01);
    wr(8'h00);
    check("R9 write zeros", rd_data, 8'h00);
    check("R12 prio_en cleared by write", {7'd0, prio_en}, 8'h00);
    wr(8'h60);
    check("R2 unused bits ignore write", rd_data, 8'h00);
  endtask

  task automatic t_wdt();
    wr(8'h1F);
    ev_wdt_to = 1; step();
    check("R4 expiry clears TO", rd_data, 8'h17);
    ev_wdt_clr = 1; step();
    check("R4/R5 clear sets TO and PD", rd_data, 8'h1F);
    ev_sleep = 1; step();
    check("R5 sleep clears PD, sets TO", rd_data, 8'h1B);
    ev_wdt_to = 1; ev_wdt_clr = 1; step();
    check("R4 expiry beats clear", rd_data, 8'h17);
    ev_sleep = 1; ev_wdt_clr = 1; step();
    check("R5 sleep beats clear", rd_data, 8'h1B);
  endtask

  task automatic t_brownout();
    wr(8'h03);
    ev_bor = 1; step();
    check("R6/R7 brown-out clears only BOR", rd_data, 8'h02);
  endtask

  task automatic t_poweron();
    wr(8'h83);
    ev_por = 1; step();
    check("R3/R12 power-on event image", rd_data, 8'h1C);
    check("R12 prio_en cleared by power-on", {7'd0, prio_en}, 8'h00);
  endtask

  task automatic t_swrst();
    wr(8'h1F);
    ev_sw_rst = 1; step();
    check("R8 soft reset clears RI", rd_data, 8'h0F);
  endtask

  task automatic t_hw_wins();
    ev_wdt_to = 1; wr_en = 1; wr_data = 8'h9F; step();
    check("R10 expiry beats write, rest written", rd_data, 8'h97);
    wr(8'h00);
    ev_wdt_clr = 1; wr_en = 1; wr_data = 8'h00; step();
    check("R10 clear beats zero write", rd_data, 8'h0C);
    ev_bor = 1; wr_en = 1; wr_data = 8'h03; step();
    check("R10 brown-out beats write of BOR", rd_data, 8'h02);
  endtask

  task automatic t_hold();
    wr(8'h95);
    step(); step(); step();
    check("R11 holds when idle", rd_data, 8'h95);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 3);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write();
        t_wdt();
        t_brownout();
        t_poweron();
        t_swrst();
        t_hw_wins();
        t_hold();
      end
      begin
        #(CLK_PERIOD * 5000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule